// File: doc/BRIEF.md
# ADC Calibration Sequence Controller

This block orders the calibration steps of a successive-approximation converter. A calibration may begin from an active-low calibrate pin (a low level holds the converter in internal reset, and the rising edge that follows starts the run) or from a one-cycle software start strobe. A 3-bit type field selects self or system calibration and which trims to run. The trims are a capacitor-DAC trim, a gain trim and an offset trim. Each trim is modelled as a fixed number of master clocks. The analog work itself lies outside this block, and only its timing is produced. The durations are parameters, so a bench can use short values and still check every phase edge exactly.

While a phase runs, the block raises a busy output and one enable strobe for that phase. A system calibration that includes a gain trim pauses after that trim with busy low. The external system offset voltage can then be applied, and a rising edge on the conversion-start input resumes the run with the offset phase. A one-cycle done pulse marks the normal end of a run. The first calibrate-pin rising edge after reset always runs a full self calibration, which serves as the power-on calibration.

Top module: `adc_cal_sequencer`

## Requirements
- R1: While the synchronized calibrate pin is low, `int_reset` is high and the sequencer is idle. A pin fall during a run aborts it with no `done`. A pin level sampled at clock edge k takes effect on the outputs at edge k+2.
- R2: A rising edge on `cal_n` starts a calibration. If the pin rises before edge k, `busy` and the first phase enable are high after edge k+2.
- R3: A `sw_start` pulse seen at edge k starts a calibration, and `busy` is high after that same edge k.
- R4: `cal_type[2]` set means system calibration. `cal_type[1:0]` selects the trims: 00 = DAC, gain, offset; 01 = gain, offset; 10 = offset only; 11 = gain only. The field is sampled at the start event, and later changes to it do not affect a run.
- R5: Phases run back to back in the order DAC, gain, offset. They last exactly DAC_CYC, GAIN_CYC and OFFS_CYC cycles. Exactly one enable is high while `busy` is high, and none is high while `busy` is low.
- R6: Type 01 skips the DAC trim. Types 10 and 11 each run their single phase and then finish.
- R7: A system calibration of type 00 or 01 drops `busy` after the gain phase and waits. A `conv_start` rising edge then starts the offset phase, with the same two-edge latency as R2.
- R8: `done` is high for exactly one cycle, in the first cycle after the final phase, and `busy` is low in that cycle.
- R9: A start request has no effect while `busy` is high, while waiting for `conv_start`, or while `pd_active` is high.
- R10: The first accepted start after reset that comes from a `cal_n` rising edge runs a self calibration of type 00, whatever `cal_type` holds.
- R11: During reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_n | input | 1 | Calibrate pin, active low, asynchronous |
| sw_start | input | 1 | One-cycle software start strobe |
| cal_type | input | 3 | Calibration type: bit 2 selects system, bits 1:0 select the trims |
| conv_start | input | 1 | Conversion start pin, asynchronous; its rising edge resumes a system run |
| pd_active | input | 1 | Power-down active; blocks new starts |
| busy | output | 1 | High while a phase runs |
| int_reset | output | 1 | Internal reset while the pin is low |
| dac_en | output | 1 | DAC trim phase active |
| gain_en | output | 1 | Gain trim phase active |
| offs_en | output | 1 | Offset trim phase active |
| done | output | 1 | One-cycle pulse at the normal end of a run |

## Verification
A software strobe driven before clock edge k shows its result one cycle later. A change on `cal_n` or `conv_start` shows its result three sampling points later, because of the two-stage synchronizer and the registered outputs. Each later change is due exactly DAC_CYC, GAIN_CYC or OFFS_CYC cycles after the previous one, and `done` clears one cycle after it rises. When the bench drives a stimulus, it queues the exact cycle number and output vector of every change it expects. A monitor samples the outputs at every falling edge and compares each observed change against the head of the queue, so an early, late, missing or extra change fails a check. Stimuli meant to be ignored add nothing to the queue, so any output change they cause is reported.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DAC,
    ST_GAIN,
    ST_OFFS,
    ST_WAIT
  } cal_state_e;

  typedef enum logic [1:0] {
    K_ALL      = 2'b00,
    K_GAINOFFS = 2'b01,
    K_OFFS     = 2'b10,
    K_GAIN     = 2'b11
  } cal_kind_e;

  typedef struct packed {
    logic      system;
    cal_kind_e kind;
  } cal_type_t;

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      last  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~last;
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= len - 1'b1;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import adc_cal_pkg::*;
#(
  parameter int DAC_CYC  = 194430,
  parameter int GAIN_CYC = 27798,
  parameter int OFFS_CYC = 27798
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      cal_low,
  input  logic      cal_rise,
  input  logic      sw_start,
  input  cal_type_t req_type,
  input  logic      conv_rise,
  input  logic      pd_active,
  output logic      busy,
  output logic      int_reset,
  output logic      dac_en,
  output logic      gain_en,
  output logic      offs_en,
  output logic      done
);
  localparam int MAX_AB = (DAC_CYC > GAIN_CYC) ? DAC_CYC : GAIN_CYC;
  localparam int MAXC   = (MAX_AB > OFFS_CYC) ? MAX_AB : OFFS_CYC;
  localparam int CW     = $clog2(MAXC + 1);

  cal_state_e    state, nstate;
  cal_type_t     held, ntype;
  logic          por_pend;
  logic          start_req, finish, load, expired;
  logic [CW-1:0] load_len;

  assign start_req = (cal_rise | sw_start) & ~cal_low & ~pd_active;

  always_comb begin
    nstate = state;
    ntype  = held;
    finish = 1'b0;
    case (state)
      ST_IDLE: if (start_req) begin
        ntype = (cal_rise && por_pend) ? '{system: 1'b0, kind: K_ALL} : req_type;
        case (ntype.kind)
          K_ALL:      nstate = ST_DAC;
          K_OFFS:     nstate = ST_OFFS;
          default:    nstate = ST_GAIN;
        endcase
      end
      ST_DAC:  if (expired) nstate = ST_GAIN;
      ST_GAIN: if (expired) begin
        if (held.kind == K_GAIN) begin
          nstate = ST_IDLE;
          finish = 1'b1;
        end else if (held.system) begin
          nstate = ST_WAIT;
        end else begin
          nstate = ST_OFFS;
        end
      end
      ST_OFFS: if (expired) begin
        nstate = ST_IDLE;
        finish = 1'b1;
      end
      ST_WAIT: if (conv_rise) nstate = ST_OFFS;
      default: nstate = ST_IDLE;
    endcase
    if (cal_low) begin
      nstate = ST_IDLE;
      finish = 1'b0;
    end
  end

  always_comb begin
    case (nstate)
      ST_DAC:  load_len = CW'(DAC_CYC);
      ST_GAIN: load_len = CW'(GAIN_CYC);
      ST_OFFS: load_len = CW'(OFFS_CYC);
      default: load_len = '0;
    endcase
  end

  assign load = (nstate != state) &&
                (nstate == ST_DAC || nstate == ST_GAIN || nstate == ST_OFFS);

  phase_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .len     (load_len),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      held      <= '{system: 1'b0, kind: K_ALL};
      por_pend  <= 1'b1;
      busy      <= 1'b0;
      int_reset <= 1'b0;
      dac_en    <= 1'b0;
      gain_en   <= 1'b0;
      offs_en   <= 1'b0;
      done      <= 1'b0;
    end else begin
      state     <= nstate;
      held      <= ntype;
      if (state == ST_IDLE && start_req) por_pend <= 1'b0;
      busy      <= (nstate == ST_DAC) || (nstate == ST_GAIN) || (nstate == ST_OFFS);
      int_reset <= cal_low;
      dac_en    <= (nstate == ST_DAC);
      gain_en   <= (nstate == ST_GAIN);
      offs_en   <= (nstate == ST_OFFS);
      done      <= finish;
    end
  end
endmodule

// File: rtl/adc_cal_sequencer.sv
module adc_cal_sequencer
  import adc_cal_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DAC_CYC     = 194430,
  parameter int GAIN_CYC    = 27798,
  parameter int OFFS_CYC    = 27798
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cal_n,
  input  logic       sw_start,
  input  logic [2:0] cal_type,
  input  logic       conv_start,
  input  logic       pd_active,
  output logic       busy,
  output logic       int_reset,
  output logic       dac_en,
  output logic       gain_en,
  output logic       offs_en,
  output logic       done
);
  logic cal_lvl, cal_rise, conv_lvl, conv_rise;

  edge_sync #(.STAGES(SYNC_STAGES)) u_cal_sync (
    .clk (clk), .rst (rst), .pin (cal_n), .level (cal_lvl), .rise (cal_rise)
  );

  edge_sync #(.STAGES(SYNC_STAGES)) u_conv_sync (
    .clk (clk), .rst (rst), .pin (conv_start), .level (conv_lvl), .rise (conv_rise)
  );

  cal_ctrl #(
    .DAC_CYC  (DAC_CYC),
    .GAIN_CYC (GAIN_CYC),
    .OFFS_CYC (OFFS_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cal_low   (~cal_lvl),
    .cal_rise  (cal_rise),
    .sw_start  (sw_start),
    .req_type  (cal_type_t'(cal_type)),
    .conv_rise (conv_rise & conv_lvl),
    .pd_active (pd_active),
    .busy      (busy),
    .int_reset (int_reset),
    .dac_en    (dac_en),
    .gain_en   (gain_en),
    .offs_en   (offs_en),
    .done      (done)
  );
endmodule

// File: rtl/adc_cal_sequencer_chk.sv
module adc_cal_sequencer_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic int_reset,
  input logic dac_en,
  input logic gain_en,
  input logic offs_en,
  input logic done
);
  // R5: one enable while busy
  p_one_phase_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> $onehot({dac_en, gain_en, offs_en}));

  // R5: no enable while not busy
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ({dac_en, gain_en, offs_en} == 3'b000));

  // R5: DAC trim is always followed by gain trim
  p_dac_then_gain_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && $fell(dac_en)) |-> gain_en);

  // R8: done follows a busy cycle with busy low, and lasts one cycle
  p_done_ends_run_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R1: internal reset forces idle
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    int_reset |-> (!busy && !done));

  // R7: offset trim entered only from gain trim or from the wait pause
  p_offs_entry_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(offs_en) |-> ($past(gain_en) || !$past(busy)));
endmodule

bind adc_cal_sequencer adc_cal_sequencer_chk chk_i (.*);

// File: tb/adc_cal_sequencer_tb_top.sv
module adc_cal_sequencer_tb_top;
  localparam int D = 7;
  localparam int G = 4;
  localparam int O = 5;

  // vector: {busy, int_reset, dac_en, gain_en, offs_en, done}
  localparam logic [5:0] V_IDLE = 6'b000000;
  localparam logic [5:0] V_IRST = 6'b010000;
  localparam logic [5:0] V_DAC  = 6'b101000;
  localparam logic [5:0] V_GAIN = 6'b100100;
  localparam logic [5:0] V_OFFS = 6'b100010;
  localparam logic [5:0] V_DONE = 6'b000001;

  typedef struct {
    int         cyc;
    logic [5:0] vec;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cal_n = 1'b0;
  logic       sw_start = 1'b0;
  logic [2:0] cal_type = 3'b111;
  logic       conv_start = 1'b0;
  logic       pd_active = 1'b0;
  logic       busy, int_reset, dac_en, gain_en, offs_en, done;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   mon_on = 1'b0;
  bit   finished = 1'b0;
  logic [5:0] last_vec = V_IDLE;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_cal_sequencer #(
    .SYNC_STAGES (2),
    .DAC_CYC     (D),
    .GAIN_CYC    (G),
    .OFFS_CYC    (O)
  ) dut_i (
    .clk (clk), .rst (rst), .cal_n (cal_n), .sw_start (sw_start),
    .cal_type (cal_type), .conv_start (conv_start), .pd_active (pd_active),
    .busy (busy), .int_reset (int_reset), .dac_en (dac_en),
    .gain_en (gain_en), .offs_en (offs_en), .done (done)
  );

  task automatic expect_at(input int c, input logic [5:0] v, input string r);
    exp_t e;
    e.cyc = c; e.vec = v; e.req = r;
    q.push_back(e);
  endtask

  // Queue the changes of one run starting at cycle s; returns the last change cycle.
  task automatic plan_seq(input int s, input logic [2:0] t, input string r, output int tend);
    int tt = s;
    if (t[1:0] == 2'b00) begin
      expect_at(tt, V_DAC, r);  tt += D;
      expect_at(tt, V_GAIN, r); tt += G;
    end else if (t[1:0] == 2'b01) begin
      expect_at(tt, V_GAIN, r); tt += G;
    end else if (t[1:0] == 2'b11) begin
      expect_at(tt, V_GAIN, r); tt += G;
      expect_at(tt, V_DONE, r); expect_at(tt + 1, V_IDLE, r);
      tend = tt + 1; return;
    end
    if (t[2] && (t[1:0] == 2'b00 || t[1:0] == 2'b01)) begin
      expect_at(tt, V_IDLE, {r, "/R7 pause"});
      tend = tt; return;
    end
    expect_at(tt, V_OFFS, r); tt += O;
    expect_at(tt, V_DONE, {r, "/R8"}); expect_at(tt + 1, V_IDLE, {r, "/R8"});
    tend = tt + 1;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic sw_go(input logic [2:0] t, input string r, output int tend);
    @(negedge clk);
    cal_type = t; sw_start = 1'b1;
    plan_seq(cyc + 1, t, r, tend);
    @(negedge clk);
    sw_start = 1'b0;
  endtask

  task automatic resume_conv(input string r, output int tend);
    @(negedge clk);
    conv_start = 1'b1;
    expect_at(cyc + 3, V_OFFS, r);
    expect_at(cyc + 3 + O, V_DONE, {r, "/R8"});
    expect_at(cyc + 4 + O, V_IDLE, {r, "/R8"});
    tend = cyc + 4 + O;
    @(negedge clk);
    @(negedge clk);
    conv_start = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (mon_on && !finished) begin
      logic [5:0] v;
      v = {busy, int_reset, dac_en, gain_en, offs_en, done};
      if (v !== last_vec) begin
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL unexpected change: cycle %0d vec %b, expected no change (R9)", cyc, v);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.cyc != cyc || e.vec !== v) begin
            errors++;
            $display("FAIL %s: cycle %0d vec %b, expected cycle %0d vec %b",
                     e.req, cyc, v, e.cyc, e.vec);
          end
        end
        last_vec = v;
      end
    end
  end

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: cycle %0d, expected completion", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int tend, c;
    repeat (3) @(negedge clk);
    // R11: reset state
    checks++;
    if ({busy, int_reset, dac_en, gain_en, offs_en, done} !== V_IDLE) begin
      errors++;
      $display("FAIL R11: vec %b, expected %b", {busy, int_reset, dac_en, gain_en, offs_en, done}, V_IDLE);
    end
    mon_on = 1'b1;
    rst = 1'b0;
    expect_at(cyc + 1, V_IRST, "R1 pin low after reset");
    wait_until(cyc + 5);

    // R10 + R2: power-on run is full self despite type 111
    @(negedge clk);
    cal_n = 1'b1;
    plan_seq(cyc + 3, 3'b000, "R10/R2 power-on", tend);
    wait_until(tend + 3);

    // R6: self gain+offset, offset only, gain only; R3 software start
    sw_go(3'b001, "R6/R3 gain+offset", tend); wait_until(tend + 3);
    sw_go(3'b010, "R6 offset only", tend);    wait_until(tend + 3);
    sw_go(3'b011, "R6 gain only", tend);      wait_until(tend + 3);

    // R4 type held, R9 start while busy ignored, R5 phase lengths
    sw_go(3'b000, "R4/R5 full self", tend);
    cal_type = 3'b011;
    @(negedge clk); sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
    cal_type = 3'b110;
    wait_until(tend + 3);

    // R9: power-down blocks a start
    @(negedge clk); pd_active = 1'b1; cal_type = 3'b001; sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
    wait_until(cyc + 8);
    pd_active = 1'b0;
    wait_until(cyc + 3);

    // R1 + R2 + R7: full system run via the pin
    @(negedge clk);
    cal_type = 3'b100; cal_n = 1'b0;
    expect_at(cyc + 3, V_IRST, "R1 pin low");
    wait_until(cyc + 6);
    @(negedge clk);
    cal_n = 1'b1;
    plan_seq(cyc + 3, 3'b100, "R2/R7 system full", tend);
    wait_until(tend + 2);
    // R9: start during pause ignored
    @(negedge clk); sw_start = 1'b1; cal_type = 3'b011;
    @(negedge clk); sw_start = 1'b0;
    wait_until(cyc + 4);
    resume_conv("R7 resume", tend);
    wait_until(tend + 3);

    // R7: system gain+offset via software
    sw_go(3'b101, "R7 system gain+offset", tend);
    wait_until(tend + 3);
    resume_conv("R7 resume", tend);
    wait_until(tend + 3);

    // R6/R7: system offset only runs without pause
    sw_go(3'b110, "R7 system offset only", tend);
    wait_until(tend + 3);

    // R1: abort during DAC phase, then restart via pin
    sw_go(3'b000, "R1 run before abort", tend);
    // sw_go queued the whole run; replace it with the DAC entry only
    q.delete();
    expect_at(cyc, V_DAC, "R1 run before abort");
    @(negedge clk);
    c = cyc;
    cal_n = 1'b0; cal_type = 3'b011;
    expect_at(c + 3, V_IRST, "R1 abort");
    wait_until(c + 14);
    @(negedge clk);
    cal_n = 1'b1;
    plan_seq(cyc + 3, 3'b011, "R1/R2 restart", tend);
    wait_until(tend + 4);

    finished = 1'b1;
    while (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      checks++; errors++;
      $display("FAIL %s: missing change, expected cycle %0d vec %b", e.req, e.cyc, e.vec);
    end
    summary();
    $finish;
  end
endmodule